// File: doc/BRIEF.md
# Shared Instruction/Data Memory Port Arbiter

This block sits between a five-stage in-order pipeline and a memory that has a single port and holds both code and data. Each cycle the fetch stage may ask to read an instruction and the memory stage may ask to read or write a data word. Only one of them can use the port in a given cycle. The block picks that requester, drives its address, write enable and write data onto the port, and sends the read data that comes back one cycle later to whichever side asked for it.

When both sides ask in the same cycle, the memory-stage access wins because it belongs to the older instruction. The block raises `fetch_stall`. While it is high, the front end keeps its program counter and its fetch/decode register, so a bubble moves into decode and the fetch is tried again in the next cycle. Each conflict therefore delays the instruction being fetched, and every instruction after it, by exactly one cycle. Instructions already further down the pipe are not affected. Reversing this priority could deadlock the pipeline, because the older instruction would then wait on a younger one.

Control is a small grant state machine. Its state register is the grant tag that lines up with the one-cycle read latency. The states are `GNT_IDLE`, meaning no access was made last cycle, `GNT_FETCH`, meaning an instruction read was made, `GNT_LOAD`, meaning a data read was made, and `GNT_STORE`, meaning a data write was made. From any state the transitions are:
- data request with write enable: to `GNT_STORE`
- data request without write enable: to `GNT_LOAD`
- fetch request alone: to `GNT_FETCH`
- no request: to `GNT_IDLE`

Top module: `umem_port_arbiter`

## Requirements
- R1: The port is enabled (`mem_en`=1) exactly when `if_req` or `dm_req` is 1. At most one access is issued per cycle.
- R2: On a data grant, `mem_addr`, `mem_we` and `mem_wdata` equal `dm_addr`, `dm_we` and `dm_wdata`. On a fetch grant, `mem_addr` equals `if_addr` and `mem_we` is 0.
- R3: When `if_req` and `dm_req` are both 1, the data request is granted.
- R4: `fetch_stall` is 1 exactly when `if_req` and `dm_req` are both 1. In the following cycle `if_rdata_vld` is 0, so a bubble enters decode.
- R5: When `dm_req` is 0, a fetch request is granted in the same cycle and `fetch_stall` stays 0.
- R6: A granted fetch returns `if_rdata_vld`=1 one cycle later, with `if_rdata` equal to the word stored at `if_addr`. `dm_rdata_vld` is 0 in that cycle.
- R7: A granted data read (`dm_we`=0) returns `dm_rdata_vld`=1 one cycle later, with the word stored at `dm_addr`. A write returns no valid on either side, and a later read of the same address sees the written value.
- R8: In a run of a load followed by three adds, the fourth instruction is fetched in cycle 4 instead of cycle 3. The instruction after it is also delayed by one cycle.
- R9: While `rst_n` is 0 and in the first cycle after reset, `fetch_stall`, `if_rdata_vld` and `dm_rdata_vld` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_req | input | 1 | Fetch stage asks to read an instruction |
| if_addr | input | AW | Fetch word address |
| dm_req | input | 1 | Memory stage asks for a load or store |
| dm_we | input | 1 | Memory stage access is a write |
| dm_addr | input | AW | Data word address |
| dm_wdata | input | DW | Store data |
| mem_en | output | 1 | Shared port access enable |
| mem_we | output | 1 | Shared port write enable |
| mem_addr | output | AW | Shared port address |
| mem_wdata | output | DW | Shared port write data |
| mem_rdata | input | DW | Shared port read data, one cycle after the access |
| fetch_stall | output | 1 | Hold PC and fetch/decode register, inject bubble |
| if_rdata_vld | output | 1 | Instruction word valid |
| if_rdata | output | DW | Instruction word |
| dm_rdata_vld | output | 1 | Load data valid |
| dm_rdata | output | DW | Load data |

## Verification
If the grant tag is corrupted, the returned word goes to the wrong side in the very next cycle. The wrong valid flag rises, or a load's data shows up as an instruction. The per-cycle reference model catches this one cycle after the faulty access. A wrong priority or stall decision changes `mem_addr` and `fetch_stall` in the same cycle as the conflict. Within a few cycles it also moves the recorded fetch cycle of the fourth instruction away from cycle 4.

// File: rtl/umem_arb_pkg.sv
package umem_arb_pkg;
    // Grant tag: which access used the port in the previous cycle
    typedef enum logic [1:0] {
        GNT_IDLE  = 2'd0,
        GNT_FETCH = 2'd1,
        GNT_LOAD  = 2'd2,
        GNT_STORE = 2'd3
    } gnt_state_e;
endpackage

// File: rtl/umem_grant_fsm.sv
module umem_grant_fsm
    import umem_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       if_req,
    input  logic       dm_req,
    input  logic       dm_we,
    output gnt_state_e gnt_now,
    output gnt_state_e gnt_tag,
    output logic       stall
);
    gnt_state_e state_q;

    // Next-state / current grant: older memory-stage access first
    always_comb begin
        if (dm_req)      gnt_now = dm_we ? GNT_STORE : GNT_LOAD;
        else if (if_req) gnt_now = GNT_FETCH;
        else             gnt_now = GNT_IDLE;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GNT_IDLE;
        else        state_q <= gnt_now;
    end

    // Outputs
    always_comb begin
        gnt_tag = state_q;
        unique case (gnt_now)
            GNT_LOAD, GNT_STORE: stall = if_req;
            GNT_FETCH, GNT_IDLE: stall = 1'b0;
        endcase
    end

    a_r4_stall_on_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        (if_req && dm_req) |-> stall)
        else $error("R4 stall missing on conflict");
    a_r5_no_stall_free: assert property (@(posedge clk) disable iff (!rst_n)
        (!dm_req) |-> !stall)
        else $error("R5 stall without conflict");
endmodule

// File: rtl/umem_port_mux.sv
module umem_port_mux
    import umem_arb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  gnt_state_e      gnt,
    input  logic [AW-1:0]   if_addr,
    input  logic [AW-1:0]   dm_addr,
    input  logic [DW-1:0]   dm_wdata,
    output logic            port_en,
    output logic            port_we,
    output logic [AW-1:0]   port_addr,
    output logic [DW-1:0]   port_wdata
);
    always_comb begin
        port_wdata = '0;
        unique case (gnt)
            GNT_IDLE: begin
                port_en = 1'b0; port_we = 1'b0; port_addr = '0;
            end
            GNT_FETCH: begin
                port_en = 1'b1; port_we = 1'b0; port_addr = if_addr;
            end
            GNT_LOAD: begin
                port_en = 1'b1; port_we = 1'b0; port_addr = dm_addr;
            end
            GNT_STORE: begin
                port_en = 1'b1; port_we = 1'b1; port_addr = dm_addr;
                port_wdata = dm_wdata;
            end
        endcase
    end
endmodule

// File: rtl/umem_rdata_steer.sv
module umem_rdata_steer
    import umem_arb_pkg::*;
#(
    parameter int DW = 32
) (
    input  gnt_state_e      tag,
    input  logic [DW-1:0]   rdata,
    output logic            if_vld,
    output logic [DW-1:0]   if_data,
    output logic            dm_vld,
    output logic [DW-1:0]   dm_data
);
    always_comb begin
        if_vld  = 1'b0;
        dm_vld  = 1'b0;
        if_data = '0;
        dm_data = '0;
        unique case (tag)
            GNT_FETCH: begin if_vld = 1'b1; if_data = rdata; end
            GNT_LOAD:  begin dm_vld = 1'b1; dm_data = rdata; end
            GNT_IDLE, GNT_STORE: ;
        endcase
    end
endmodule

// File: rtl/umem_port_arbiter.sv
module umem_port_arbiter
    import umem_arb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          if_req,
    input  logic [AW-1:0] if_addr,
    input  logic          dm_req,
    input  logic          dm_we,
    input  logic [AW-1:0] dm_addr,
    input  logic [DW-1:0] dm_wdata,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          fetch_stall,
    output logic          if_rdata_vld,
    output logic [DW-1:0] if_rdata,
    output logic          dm_rdata_vld,
    output logic [DW-1:0] dm_rdata
);
    gnt_state_e gnt_now;
    gnt_state_e gnt_tag;

    umem_grant_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .if_req(if_req), .dm_req(dm_req),
        .dm_we(dm_we), .gnt_now(gnt_now), .gnt_tag(gnt_tag), .stall(fetch_stall)
    );

    umem_port_mux #(.AW(AW), .DW(DW)) u_mux (
        .gnt(gnt_now), .if_addr(if_addr), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
        .port_en(mem_en), .port_we(mem_we), .port_addr(mem_addr), .port_wdata(mem_wdata)
    );

    umem_rdata_steer #(.DW(DW)) u_steer (
        .tag(gnt_tag), .rdata(mem_rdata),
        .if_vld(if_rdata_vld), .if_data(if_rdata),
        .dm_vld(dm_rdata_vld), .dm_data(dm_rdata)
    );

    a_r1_port_enable: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en == (if_req || dm_req))
        else $error("R1 port enable mismatch");
    a_r3_data_wins: assert property (@(posedge clk) disable iff (!rst_n)
        dm_req |-> (mem_addr == dm_addr && mem_we == dm_we))
        else $error("R3 data request not granted");
    a_r2_fetch_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        (if_req && !dm_req) |-> (mem_addr == if_addr && !mem_we))
        else $error("R2 fetch port drive wrong");
    a_r6_fetch_return: assert property (@(posedge clk) disable iff (!rst_n)
        (if_req && !dm_req) |=> (if_rdata_vld && !dm_rdata_vld))
        else $error("R6 fetch data not returned");
    a_r7_load_return: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_req && !dm_we) |=> (dm_rdata_vld && !if_rdata_vld))
        else $error("R7 load data not returned");
    a_r7_one_return: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({if_rdata_vld, dm_rdata_vld}))
        else $error("R7 both valids high");
endmodule

// File: tb/umem_port_arbiter_test.sv
module umem_port_arbiter_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NPROG = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          if_req = 1'b0;
    logic [AW-1:0] if_addr = '0;
    logic          dm_req = 1'b0;
    logic          dm_we = 1'b0;
    logic [AW-1:0] dm_addr = '0;
    logic [DW-1:0] dm_wdata = '0;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          fetch_stall, if_rdata_vld, dm_rdata_vld;
    logic [DW-1:0] if_rdata, dm_rdata;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    umem_port_arbiter #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .if_req(if_req), .if_addr(if_addr),
        .dm_req(dm_req), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .fetch_stall(fetch_stall),
        .if_rdata_vld(if_rdata_vld), .if_rdata(if_rdata),
        .dm_rdata_vld(dm_rdata_vld), .dm_rdata(dm_rdata)
    );

    // Program: [31:30] op (0 add, 1 load, 2 store), [7:0] data word address
    function automatic logic [31:0] prog(int i);
        case (i)
            0: return {2'd1, 22'd0, 8'd40};
            4: return {2'd2, 22'd0, 8'd41};
            6: return {2'd1, 22'd0, 8'd41};
            default: return {2'd0, 22'd0, 8'(i)};
        endcase
    endfunction

    function automatic logic [31:0] init_word(int a);
        return (a < NPROG) ? prog(a) : (32'hD000_0000 + 32'(a));
    endfunction

    // Memory array driven from the shared port
    logic [DW-1:0] arr [0:(1<<AW)-1];
    initial for (int a = 0; a < (1<<AW); a++) arr[a] = init_word(a);
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) arr[mem_addr] <= mem_wdata;
            else        mem_rdata <= arr[mem_addr];
        end
    end

    // Bench-side reference contents, updated from requester inputs only
    logic [DW-1:0] ref_mem [0:(1<<AW)-1];
    initial for (int a = 0; a < (1<<AW); a++) ref_mem[a] = init_word(a);

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference expectations for registered outputs
    bit            e_ivld = 0, e_dvld = 0;
    logic [DW-1:0] e_idata = '0, e_ddata = '0;
    int            fetch_cyc [0:NPROG-1];
    bit            done = 0;

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        bit            d_v = 0, x_v = 0, m_v = 0;
        logic [31:0]   d_i = '0, x_i = '0, m_i = '0;
        int            pc = 0;
        logic [AW-1:0] ld_addr;
        for (int i = 0; i < NPROG; i++) fetch_cyc[i] = -1;

        // R9: reset state
        repeat (3) @(negedge clk);
        #1;
        check(!fetch_stall && !if_rdata_vld && !dm_rdata_vld, "R9 reset outputs",
              {fetch_stall, if_rdata_vld, dm_rdata_vld}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int cyc = 0; cyc < 24; cyc++) begin
            bit grant_f;
            // Drive requests from the bench pipeline
            if_req  = (pc < NPROG);
            if_addr = AW'(pc);
            dm_req  = m_v && (m_i[31:30] != 2'd0);
            dm_we   = m_v && (m_i[31:30] == 2'd2);
            dm_addr = m_i[AW-1:0];
            dm_wdata = 32'hCAFE_0000 | 32'(m_i[7:0]);
            #1;
            // Registered outputs for this cycle
            check(if_rdata_vld == e_ivld, "R6 if_rdata_vld", 64'(if_rdata_vld), 64'(e_ivld));
            check(dm_rdata_vld == e_dvld, "R7 dm_rdata_vld", 64'(dm_rdata_vld), 64'(e_dvld));
            if (e_ivld) check(if_rdata == e_idata, "R6 if_rdata", 64'(if_rdata), 64'(e_idata));
            if (e_dvld) check(dm_rdata == e_ddata, "R7 dm_rdata", 64'(dm_rdata), 64'(e_ddata));
            if (cyc == 0) check(!if_rdata_vld && !dm_rdata_vld, "R9 first cycle", 0, 0);
            // Combinational port behaviour
            check(mem_en == (if_req || dm_req), "R1 mem_en", 64'(mem_en), 64'(if_req || dm_req));
            check(fetch_stall == (if_req && dm_req), "R4/R5 fetch_stall",
                  64'(fetch_stall), 64'(if_req && dm_req));
            if (dm_req) begin
                check(mem_addr == dm_addr && mem_we == dm_we, "R3 data wins",
                      {mem_we, mem_addr}, {dm_we, dm_addr});
                if (dm_we) check(mem_wdata == dm_wdata, "R2 store data",
                                 64'(mem_wdata), 64'(dm_wdata));
            end else if (if_req) begin
                check(mem_addr == if_addr && !mem_we, "R2 fetch drive",
                      {mem_we, mem_addr}, {1'b0, if_addr});
            end
            // Next-cycle expectations
            grant_f = if_req && !dm_req;
            e_ivld  = grant_f;
            e_idata = grant_f ? prog(pc) : '0;
            e_dvld  = dm_req && !dm_we;
            e_ddata = (dm_req && !dm_we) ? ref_mem[dm_addr] : '0;
            if (dm_req && dm_we) ref_mem[dm_addr] = dm_wdata;
            if (grant_f) fetch_cyc[pc] = cyc;
            // Advance bench pipeline
            m_v = x_v; m_i = x_i;
            x_v = d_v; x_i = d_i;
            d_v = grant_f; d_i = grant_f ? prog(pc) : '0;
            if (grant_f) pc++;
            @(negedge clk);
        end

        // R8: one-cycle push-out per conflict
        check(fetch_cyc[2] == 2, "R8 third fetch on time", 64'(fetch_cyc[2]), 2);
        check(fetch_cyc[3] == 4, "R8 fourth fetch one cycle late", 64'(fetch_cyc[3]), 4);
        check(fetch_cyc[4] == 5, "R8 later fetch also shifted", 64'(fetch_cyc[4]), 5);
        // R7: load after store sees written value
        ld_addr = 8'd41;
        check(arr[ld_addr] == (32'hCAFE_0000 | 32'd41), "R7 store reached memory",
              64'(arr[ld_addr]), 64'(32'hCAFE_0029));

        // Separate pattern: idle port, then lone data read
        if_req = 0; dm_req = 0; #1;
        check(!mem_en && !fetch_stall, "R1 idle port", {mem_en, fetch_stall}, 0);
        @(negedge clk);
        dm_req = 1; dm_we = 0; dm_addr = 8'd50; #1;
        check(!fetch_stall, "R5 no fetch no stall", 64'(fetch_stall), 0);
        @(negedge clk);
        dm_req = 0; #1;
        check(dm_rdata_vld && dm_rdata == (32'hD000_0000 + 32'd50) && !if_rdata_vld,
              "R7 lone load", 64'(dm_rdata), 64'(32'hD000_0032));

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule